// File: doc/BRIEF.md
# Bus Bridge Request Router

This block makes the forwarding decision for one port of a packet-switched peripheral bus bridge. Each parsed header gives a packet kind, the side it arrived on, a target address and a 16-bit device identifier. The block answers with one of three routes: send it to the child side (DOWN), send it toward the root (UP), or discard it (DROP). Memory requests are steered by their address page against a programmed memory window. Completions and configuration requests are steered by the bus number inside the identifier, checked against a programmed bus-number span. An upstream-mastering enable stops any traffic that originates on the child side from going toward the root.

Headers enter on a valid/ready interface. The decision leaves one cycle later on a second valid/ready interface, together with the header's tag, address and identifier. The input is ready whenever the output register is empty or is being taken in the same cycle. While `dec_valid` is high and `dec_ready` is low, the output holds every field and `hdr_ready` stays low, so no header is accepted. Software programs the span, the window and the enable through a plain write port. Reset clears all of them, so nothing is forwarded until the bridge is set up.

Top module: `bus_bridge_router`

## Requirements
- R1: The identifier holds the bus number in bits 15:8, the device in bits 7:3 and the function in bits 2:0. Only the bus number is used for routing. A completion or configuration request that arrives from above (`hdr_from_below`=0) with a bus number inside the span is routed DOWN (`dec_route`=1). Both the secondary and subordinate boundaries count as inside.
- R2: The bus span runs from the secondary bus to the subordinate bus. It is empty when the secondary bus is 0, or when the secondary bus is greater than the subordinate bus. A span with secondary equal to subordinate holds exactly one bus.
- R3: A memory request from above is routed DOWN only when its address page (address bits above bit 11) lies within the inclusive range from the base page to the limit page, and the base page is not zero. Any other memory request from above is dropped (`dec_route`=0) with `dec_unsup`=1.
- R4: A memory request from below whose page lies outside the window is routed UP (`dec_route`=2) when mastering is enabled. One whose page lies inside the window is dropped with `dec_unsup`=0. Nothing that arrives from below is ever routed DOWN.
- R5: When mastering is disabled, no header is routed UP. Memory requests and completions from below are then dropped with `dec_unsup`=0.
- R6: A completion from below whose bus number lies outside the span is routed UP when mastering is enabled. One whose bus number lies inside the span is dropped with `dec_unsup`=0.
- R7: A completion or configuration request from above whose bus number lies outside the span is dropped with `dec_unsup`=1. `dec_unsup` is only ever set together with DROP.
- R8: A configuration request from below (kind 2) is dropped with `dec_unsup`=0. A header of the reserved kind 3 is dropped with `dec_unsup`=1, whichever side it arrives on. The kind codes are 0 for memory and 1 for completion.
- R9: A header accepted at a clock edge shows its decision on `dec_valid` after that same edge. `hdr_ready` equals `!dec_valid || dec_ready`. While the output is stalled, `dec_valid` and all output fields hold steady.
- R10: After reset, `dec_valid`=0, mastering is disabled, and the span and window are cleared. As a result, no header is routed DOWN or UP until the bridge is programmed.
- R11: A write with `cfg_wr_en`=1 takes effect on the next edge. The `cfg_wr_sel` value picks the target: 0 sets the span (data bits 7:0 secondary, 15:8 subordinate), 1 sets the base page, 2 sets the limit page, and 3 sets the mastering enable from data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Configuration target select |
| cfg_wr_data | input | CFG_W | Configuration write data |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_kind | input | 2 | 0 memory, 1 completion, 2 configuration, 3 reserved |
| hdr_from_below | input | 1 | 1 when the header arrived on the child side |
| hdr_addr | input | ADDR_W | Memory target address |
| hdr_id | input | 16 | Routing identifier (bus, device, function) |
| hdr_tag | input | TAG_W | Opaque tag carried with the decision |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision taken by the consumer |
| dec_route | output | 2 | 0 DROP, 1 DOWN, 2 UP |
| dec_unsup | output | 1 | Drop flagged as unsupported |
| dec_addr | output | ADDR_W | Address of the decided header |
| dec_id | output | 16 | Identifier of the decided header |
| dec_tag | output | TAG_W | Tag of the decided header |

## Verification
The bench builds the router with a 20-bit address, which leaves 8-bit page numbers, and a 4-bit tag. With 8-bit pages, the window edges, page zero and an inverted base/limit pair can all be reached with small literal addresses. The 4-bit tag wraps during the run, so the scoreboard also sees the tag values reused. The consumer's ready signal is driven always high, in a repeating stall pattern and held low, so decisions are checked under back-pressure as well as in free flow.

// File: rtl/brr_pkg.sv
package brr_pkg;

  typedef enum logic [1:0] {
    KIND_MEM  = 2'd0,
    KIND_CPL  = 2'd1,
    KIND_CFG  = 2'd2,
    KIND_RSVD = 2'd3
  } hdr_kind_e;

  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_DOWN = 2'd1,
    RT_UP   = 2'd2,
    RT_BAD  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    SEL_SPAN   = 2'd0,
    SEL_BASE   = 2'd1,
    SEL_LIMIT  = 2'd2,
    SEL_MASTER = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
  } dev_id_t;

  localparam int PAGE_SHIFT = 12;

endpackage

// File: rtl/brr_cfg_regs.sv
module brr_cfg_regs
  import brr_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int CFG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [7:0]        sec_bus,
  output logic [7:0]        sub_bus,
  output logic [PAGE_W-1:0] base_pg,
  output logic [PAGE_W-1:0] limit_pg,
  output logic              master_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_bus   <= '0;
      sub_bus   <= '0;
      base_pg   <= '0;
      limit_pg  <= '0;
      master_en <= 1'b0;
    end else if (wr_en) begin
      unique case (cfg_sel_e'(wr_sel))
        SEL_SPAN: begin
          sec_bus <= wr_data[7:0];
          sub_bus <= wr_data[15:8];
        end
        SEL_BASE:   base_pg   <= wr_data[PAGE_W-1:0];
        SEL_LIMIT:  limit_pg  <= wr_data[PAGE_W-1:0];
        SEL_MASTER: master_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  AST_MASTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == SEL_MASTER) |=> master_en == $past(wr_data[0])); // R11
  AST_SPAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == SEL_SPAN) |=> sec_bus == $past(wr_data[7:0])); // R11
  AST_SPAN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sec_bus) && $stable(sub_bus) && $stable(master_en)); // R11

endmodule

// File: rtl/brr_span_hit.sv
module brr_span_hit #(
  parameter int W = 8
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);

  logic lo_live;

  // A zero lower bound marks the span as unprogrammed.
  assign lo_live = (lo != '0);
  assign hit     = lo_live && (key >= lo) && (key <= hi);

endmodule

// File: rtl/brr_decide.sv
module brr_decide
  import brr_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       from_below,
  input  logic       bus_hit,
  input  logic       win_hit,
  input  logic       master_en,
  output logic [1:0] route,
  output logic       unsup
);

  route_e rt;

  always_comb begin
    rt    = RT_DROP;
    unsup = 1'b0;
    unique case (hdr_kind_e'(kind))
      KIND_MEM: begin
        if (!from_below) begin
          if (win_hit) rt = RT_DOWN;
          else         unsup = 1'b1;
        end else if (!win_hit && master_en) begin
          rt = RT_UP;
        end
      end
      KIND_CPL: begin
        if (!from_below) begin
          if (bus_hit) rt = RT_DOWN;
          else         unsup = 1'b1;
        end else if (!bus_hit && master_en) begin
          rt = RT_UP;
        end
      end
      KIND_CFG: begin
        if (!from_below) begin
          if (bus_hit) rt = RT_DOWN;
          else         unsup = 1'b1;
        end
      end
      default: unsup = 1'b1;
    endcase
    route = rt;
  end

endmodule

// File: rtl/bus_bridge_router.sv
module bus_bridge_router
  import brr_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int TAG_W  = 4,
  localparam int PAGE_W = ADDR_W - 12,
  localparam int CFG_W  = (PAGE_W > 16) ? PAGE_W : 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [1:0]        hdr_kind,
  input  logic              hdr_from_below,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [15:0]       hdr_id,
  input  logic [TAG_W-1:0]  hdr_tag,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [1:0]        dec_route,
  output logic              dec_unsup,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [15:0]       dec_id,
  output logic [TAG_W-1:0]  dec_tag
);

  logic [7:0]        sec_bus, sub_bus;
  logic [PAGE_W-1:0] base_pg, limit_pg;
  logic              master_en;
  logic              bus_hit, win_hit;
  logic [1:0]        d_route;
  logic              d_unsup;
  dev_id_t           key_id;
  logic [PAGE_W-1:0] key_pg;
  logic              take;

  assign key_id = dev_id_t'(hdr_id);
  assign key_pg = hdr_addr[ADDR_W-1:PAGE_SHIFT];

  brr_cfg_regs #(.PAGE_W(PAGE_W), .CFG_W(CFG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_sel    (cfg_wr_sel),
    .wr_data   (cfg_wr_data),
    .sec_bus   (sec_bus),
    .sub_bus   (sub_bus),
    .base_pg   (base_pg),
    .limit_pg  (limit_pg),
    .master_en (master_en)
  );

  brr_span_hit #(.W(8)) u_bus_hit (
    .key (key_id.bus),
    .lo  (sec_bus),
    .hi  (sub_bus),
    .hit (bus_hit)
  );

  brr_span_hit #(.W(PAGE_W)) u_win_hit (
    .key (key_pg),
    .lo  (base_pg),
    .hi  (limit_pg),
    .hit (win_hit)
  );

  brr_decide u_decide (
    .kind       (hdr_kind),
    .from_below (hdr_from_below),
    .bus_hit    (bus_hit),
    .win_hit    (win_hit),
    .master_en  (master_en),
    .route      (d_route),
    .unsup      (d_unsup)
  );

  // Single output register; input is blocked while it is held.
  assign hdr_ready = !dec_valid || dec_ready;
  assign take      = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_route <= RT_DROP;
      dec_unsup <= 1'b0;
      dec_addr  <= '0;
      dec_id    <= '0;
      dec_tag   <= '0;
    end else if (hdr_ready) begin
      dec_valid <= hdr_valid;
      if (hdr_valid) begin
        dec_route <= d_route;
        dec_unsup <= d_unsup;
        dec_addr  <= hdr_addr;
        dec_id    <= hdr_id;
        dec_tag   <= hdr_tag;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_route) && $stable(dec_tag)
                                && $stable(dec_unsup) && $stable(dec_id)); // R9
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |-> !hdr_ready); // R9
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dec_valid && dec_tag == $past(hdr_tag)); // R9
  AST_UP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take && (d_route == RT_UP) |-> master_en); // R5
  AST_NO_DOWN_FROM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    take && hdr_from_below |-> d_route != RT_DOWN); // R4
  AST_UNSUP_IS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_unsup |-> dec_route == RT_DROP); // R7
  AST_LEGAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_route != RT_BAD); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !dec_valid); // R10

endmodule

// File: tb/tb_bus_bridge_router.sv
module tb_bus_bridge_router;

  localparam int ADDR_W = 20;
  localparam int TAG_W  = 4;
  localparam int CFG_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [1:0]        cfg_wr_sel = '0;
  logic [CFG_W-1:0]  cfg_wr_data = '0;
  logic              hdr_valid = 1'b0;
  logic              hdr_ready;
  logic [1:0]        hdr_kind = '0;
  logic              hdr_from_below = 1'b0;
  logic [ADDR_W-1:0] hdr_addr = '0;
  logic [15:0]       hdr_id = '0;
  logic [TAG_W-1:0]  hdr_tag = '0;
  logic              dec_valid;
  logic              dec_ready = 1'b1;
  logic [1:0]        dec_route;
  logic              dec_unsup;
  logic [ADDR_W-1:0] dec_addr;
  logic [15:0]       dec_id;
  logic [TAG_W-1:0]  dec_tag;

  bus_bridge_router #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_kind(hdr_kind),
    .hdr_from_below(hdr_from_below), .hdr_addr(hdr_addr), .hdr_id(hdr_id),
    .hdr_tag(hdr_tag), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_route(dec_route), .dec_unsup(dec_unsup), .dec_addr(dec_addr),
    .dec_id(dec_id), .dec_tag(dec_tag)
  );

  always #5 clk = ~clk;

  localparam logic [1:0] K_MEM = 2'd0, K_CPL = 2'd1, K_CFG = 2'd2, K_RSV = 2'd3;
  localparam logic [1:0] DROP = 2'd0, DOWN = 2'd1, UP = 2'd2;

  typedef struct {
    logic [TAG_W-1:0]  tag;
    logic [1:0]        rt;
    logic              un;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       id;
    string             rq;
  } exp_t;

  exp_t             sb[$];
  int               checks = 0;
  int               errors = 0;
  int               ready_mode = 0;
  int               cyc = 0;
  logic [TAG_W-1:0] tagc = '0;
  bit               done = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // consumer ready generator
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: dec_ready = 1'b1;
      1: dec_ready = (cyc % 3) != 0;
      default: dec_ready = 1'b0;
    endcase
  end

  // monitor: the handshake happens at the next rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && dec_valid && dec_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected decision", dec_tag, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(dec_tag == e.tag && dec_id == e.id && dec_addr == e.addr,
              e.rq, "tag", dec_tag, e.tag);
        check(dec_route == e.rt, e.rq, "route", dec_route, e.rt);
        check(dec_unsup == e.un, e.rq, "unsup", dec_unsup, e.un);
      end
    end
  end

  task automatic send(input logic [1:0] k, input logic b, input logic [ADDR_W-1:0] a,
                      input logic [15:0] id, input logic [1:0] er, input logic eu,
                      input string rq);
    exp_t e;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_kind = k; hdr_from_below = b;
    hdr_addr = a; hdr_id = id; hdr_tag = tagc;
    #1;
    while (!hdr_ready) begin
      @(negedge clk); #1;
    end
    e.tag = tagc; e.rt = er; e.un = eu; e.addr = a; e.id = id; e.rq = rq;
    sb.push_back(e);
    tagc++;
    @(posedge clk); #1;
    hdr_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CFG_W-1:0] d);
    drain();
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(dec_valid == 1'b0, "R10", "dec_valid after reset", dec_valid, 0);
    check(hdr_ready == 1'b1, "R9", "hdr_ready idle", hdr_ready, 1);

    // R10: unprogrammed bridge forwards nothing
    send(K_MEM, 1, 20'h50000, 16'h0100, DROP, 0, "R10");
    send(K_CPL, 1, 20'h00000, 16'h0700, DROP, 0, "R10");
    send(K_MEM, 0, 20'h00000, 16'h0100, DROP, 1, "R3");
    send(K_CFG, 0, 20'h00000, 16'h0000, DROP, 1, "R2");

    // R11 programming: span 3..5, window pages 0x10..0x1F, mastering on
    wr(2'd0, 16'h0503);
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h001F);
    wr(2'd3, 16'h0001);

    ready_mode = 1;
    send(K_CFG, 0, 20'h0, 16'h0300, DOWN, 0, "R1");
    send(K_CFG, 0, 20'h0, 16'h05F8, DOWN, 0, "R1");
    send(K_CFG, 0, 20'h0, 16'h0600, DROP, 1, "R7");
    send(K_CFG, 0, 20'h0, 16'h0200, DROP, 1, "R7");
    send(K_MEM, 0, 20'h10000, 16'h0100, DOWN, 0, "R3");
    send(K_MEM, 0, 20'h1FFFF, 16'h0100, DOWN, 0, "R3");
    send(K_MEM, 0, 20'h0FFFF, 16'h0100, DROP, 1, "R3");
    send(K_MEM, 0, 20'h20000, 16'h0100, DROP, 1, "R3");
    send(K_MEM, 1, 20'h20000, 16'h0400, UP, 0, "R4");
    send(K_MEM, 1, 20'h15000, 16'h0400, DROP, 0, "R4");
    send(K_CPL, 1, 20'h0, 16'h0100, UP, 0, "R6");
    send(K_CPL, 1, 20'h0, 16'h0408, DROP, 0, "R6");
    send(K_CPL, 0, 20'h0, 16'h0400, DOWN, 0, "R1");
    send(K_CPL, 0, 20'h0, 16'h0900, DROP, 1, "R7");
    send(K_CFG, 1, 20'h0, 16'h0400, DROP, 0, "R8");
    send(K_RSV, 0, 20'h15000, 16'h0400, DROP, 1, "R8");
    send(K_RSV, 1, 20'h20000, 16'h0100, DROP, 1, "R8");
    ready_mode = 0;

    // R2: inverted span, then single-bus span
    wr(2'd0, 16'h0506);
    send(K_CFG, 0, 20'h0, 16'h0500, DROP, 1, "R2");
    wr(2'd0, 16'h0404);
    send(K_CFG, 0, 20'h0, 16'h0400, DOWN, 0, "R2");
    send(K_CFG, 0, 20'h0, 16'h0500, DROP, 1, "R2");

    // R3: base page zero disables the window; inverted window is empty
    wr(2'd1, 16'h0000);
    send(K_MEM, 0, 20'h05000, 16'h0100, DROP, 1, "R3");
    wr(2'd1, 16'h0020);
    send(K_MEM, 0, 20'h20000, 16'h0100, DROP, 1, "R3");
    send(K_MEM, 0, 20'h1F000, 16'h0100, DROP, 1, "R3");

    // R5: mastering disabled
    wr(2'd3, 16'h0000);
    send(K_MEM, 1, 20'h30000, 16'h0400, DROP, 0, "R5");
    send(K_CPL, 1, 20'h0, 16'h0100, DROP, 0, "R5");

    // R9: one-cycle latency
    drain();
    send(K_CFG, 0, 20'h0, 16'h0400, DOWN, 0, "R9");
    @(negedge clk); #1;
    check(dec_valid == 1'b1, "R9", "latency dec_valid", dec_valid, 1);
    drain();

    // R9: stall holds output and blocks input
    ready_mode = 2;
    @(negedge clk); @(negedge clk);
    send(K_MEM, 0, 20'h40000, 16'h0100, DROP, 1, "R9");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(hdr_ready == 1'b0, "R9", "hdr_ready stalled", hdr_ready, 0);
      check(dec_valid == 1'b1 && dec_addr == 20'h40000, "R9", "held addr", dec_addr, 20'h40000);
    end
    ready_mode = 0;
    drain();
    check(sb.size() == 0, "R9", "scoreboard empty", sb.size(), 0);
    finish_run();
  end

endmodule